// File: doc/BRIEF.md
# Byte ALU with Carry and Zero Flags

This block is the arithmetic core of a small soft microcontroller. Each cycle it takes an operation select, an 8-bit first operand, and a second operand. The second operand comes either from a register value or from an immediate constant. The result, the write-back enable and the next carry and zero values are all produced combinationally.

The carry and zero flags are held in registers inside the block. They are loaded on a rising clock edge only while the execute strobe is high. Operations that read the carry flag can therefore be chained across bytes to build wider adders, subtractors and shifters.

The operation set covers the following:
- load
- add and subtract, each with or without the carry flag as carry-in or borrow-in
- bitwise AND, OR and XOR
- a non-writing parity test
- a non-writing compare
- ten one-bit shift and rotate forms

Top module: `alu8_core`

## Requirements
- R1: With `opSel` 1 the result is opA+B modulo 256. With `opSel` 2 the result is opA+B+carryFlag. In both cases the next carry is the carry out of bit 7.
- R2: With `opSel` 3 the result is opA-B modulo 256. With `opSel` 4 the result is opA-B-carryFlag. In both cases the next carry is 1 exactly when B plus the borrow-in exceeds opA as unsigned numbers.
- R3: The codes 5 (AND), 6 (OR) and 7 (XOR) write the bitwise result, and the next carry is always 0.
- R4: Code 8 (test) drives `writeEn` low. The next carry is the odd parity of opA&B, and the next zero is set when opA&B is 0x00.
- R5: Code 9 (compare) drives `writeEn` low and sets the next carry and zero exactly as code 3 would.
- R6: Code 0 (load) writes B as the result and leaves both flags unchanged.
- R7: The left shifts take opA. Codes 10/11/12/13/14 fill bit 0 with, in order: 0, 1, old bit 0, the carry flag, and old bit 7. For all of them the next carry is old bit 7.
- R8: The right shifts take opA. Codes 15/16/17/18/19 fill bit 7 with, in order: 0, 1, old bit 7, the carry flag, and old bit 0. For all of them the next carry is old bit 0.
- R9: For every code from 1 to 19, the next zero is 1 exactly when the result (or the internal value, for test and compare) is 0x00.
- R10: Both flags reset to 0. They take the next values only on a rising edge with `exec` high, and `writeEn` is low whenever `exec` is low.
- R11: B is `immB` when `useImm` is 1 and `regB` otherwise.
- R12: Codes 20 to 31 drive `writeEn` low and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Execute strobe; allows flag update and write-back |
| opSel | input | 5 | Operation code |
| opA | input | 8 | First operand |
| regB | input | 8 | Second operand from register |
| immB | input | 8 | Second operand as immediate |
| useImm | input | 1 | Selects immB as second operand |
| result | output | 8 | Operation result |
| writeEn | output | 1 | Result should be written back |
| carryNext | output | 1 | Carry value to be stored |
| zeroNext | output | 1 | Zero value to be stored |
| carryFlag | output | 1 | Stored carry flag |
| zeroFlag | output | 1 | Stored zero flag |

## Verification
An operation that consumes the carry flag (add or subtract with carry, or a shift through carry) reads the stored flag and produces its replacement in the same cycle. The new value must land only at the edge and must not disturb the operand already used. The bench provokes this with back-to-back chained multi-byte additions, subtractions and shifts with `exec` held high, then with long random runs of mixed operations and randomly gated `exec`. A bench model carries its own flag copy forward and judges the combinational outputs before each edge and the stored flags after it.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  parameter int DATA_W = 8;
  parameter int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 5'd0,  OP_ADD  = 5'd1,  OP_ADDC = 5'd2,  OP_SUB  = 5'd3,
    OP_SUBC = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_TEST = 5'd8,  OP_CMP  = 5'd9,
    OP_SL0  = 5'd10, OP_SL1  = 5'd11, OP_SLX  = 5'd12, OP_SLC  = 5'd13, OP_RL = 5'd14,
    OP_SR0  = 5'd15, OP_SR1  = 5'd16, OP_SRX  = 5'd17, OP_SRC  = 5'd18, OP_RR = 5'd19
  } op_e;

  typedef enum logic [1:0] {UNIT_PASS, UNIT_ARITH, UNIT_LOGIC, UNIT_SHIFT} unit_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logic_e;
  typedef enum logic [2:0] {FILL_ZERO, FILL_ONE, FILL_EDGE, FILL_CARRY, FILL_ROT} fill_e;

  typedef struct packed {
    unit_e  unit;
    logic   isSub;
    logic   useCarry;
    logic_e logicOp;
    logic   parityC;
    logic   shRight;
    fill_e  fill;
    logic   writeBack;
    logic   flagUpd;
  } alu_ctrl_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic            exec,
  input  logic [OP_W-1:0] opSel,
  output alu_ctrl_t       ctrl,
  output logic            writeEn
);
  always_comb begin
    ctrl = '0;
    ctrl.writeBack = 1'b1;
    ctrl.flagUpd   = 1'b1;
    case (opSel)
      OP_LOAD: begin ctrl.unit = UNIT_PASS; ctrl.flagUpd = 1'b0; end
      OP_ADD:  ctrl.unit = UNIT_ARITH;
      OP_ADDC: begin ctrl.unit = UNIT_ARITH; ctrl.useCarry = 1'b1; end
      OP_SUB:  begin ctrl.unit = UNIT_ARITH; ctrl.isSub = 1'b1; end
      OP_SUBC: begin ctrl.unit = UNIT_ARITH; ctrl.isSub = 1'b1; ctrl.useCarry = 1'b1; end
      OP_CMP:  begin ctrl.unit = UNIT_ARITH; ctrl.isSub = 1'b1; ctrl.writeBack = 1'b0; end
      OP_AND:  begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LG_AND; end
      OP_OR:   begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LG_OR; end
      OP_XOR:  begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LG_XOR; end
      OP_TEST: begin
        ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LG_AND;
        ctrl.parityC = 1'b1; ctrl.writeBack = 1'b0;
      end
      OP_SL0:  begin ctrl.unit = UNIT_SHIFT; ctrl.fill = FILL_ZERO; end
      OP_SL1:  begin ctrl.unit = UNIT_SHIFT; ctrl.fill = FILL_ONE; end
      OP_SLX:  begin ctrl.unit = UNIT_SHIFT; ctrl.fill = FILL_EDGE; end
      OP_SLC:  begin ctrl.unit = UNIT_SHIFT; ctrl.fill = FILL_CARRY; end
      OP_RL:   begin ctrl.unit = UNIT_SHIFT; ctrl.fill = FILL_ROT; end
      OP_SR0:  begin ctrl.unit = UNIT_SHIFT; ctrl.shRight = 1'b1; ctrl.fill = FILL_ZERO; end
      OP_SR1:  begin ctrl.unit = UNIT_SHIFT; ctrl.shRight = 1'b1; ctrl.fill = FILL_ONE; end
      OP_SRX:  begin ctrl.unit = UNIT_SHIFT; ctrl.shRight = 1'b1; ctrl.fill = FILL_EDGE; end
      OP_SRC:  begin ctrl.unit = UNIT_SHIFT; ctrl.shRight = 1'b1; ctrl.fill = FILL_CARRY; end
      OP_RR:   begin ctrl.unit = UNIT_SHIFT; ctrl.shRight = 1'b1; ctrl.fill = FILL_ROT; end
      default: begin ctrl.writeBack = 1'b0; ctrl.flagUpd = 1'b0; end
    endcase
  end

  assign writeEn = exec & ctrl.writeBack;
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         exec,
  input  alu_ctrl_t    ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] regB,
  input  logic [W-1:0] immB,
  input  logic         useImm,
  output logic [W-1:0] result,
  output logic         carryNext,
  output logic         zeroNext,
  output logic         carryFlag,
  output logic         zeroFlag
);
  logic [W-1:0] opB, bArith, logicRes, shiftRes, core;
  logic [W:0]   sum;
  logic         carryIn, arithCarry, fillBit, shiftCarry, coreCarry;

  assign opB = useImm ? immB : regB;

  // Subtract is A + ~B + ~borrowIn; borrow-out is the inverted carry-out.
  always_comb begin
    carryIn    = ctrl.useCarry & carryFlag;
    bArith     = ctrl.isSub ? ~opB : opB;
    sum        = {1'b0, opA} + {1'b0, bArith} + {{W{1'b0}}, ctrl.isSub ^ carryIn};
    arithCarry = sum[W] ^ ctrl.isSub;
  end

  always_comb begin
    case (ctrl.logicOp)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    case (ctrl.fill)
      FILL_ONE:   fillBit = 1'b1;
      FILL_EDGE:  fillBit = ctrl.shRight ? opA[W-1] : opA[0];
      FILL_CARRY: fillBit = carryFlag;
      FILL_ROT:   fillBit = ctrl.shRight ? opA[0] : opA[W-1];
      default:    fillBit = 1'b0;
    endcase
    shiftRes   = ctrl.shRight ? {fillBit, opA[W-1:1]} : {opA[W-2:0], fillBit};
    shiftCarry = ctrl.shRight ? opA[0] : opA[W-1];
  end

  always_comb begin
    case (ctrl.unit)
      UNIT_ARITH: begin core = sum[W-1:0]; coreCarry = arithCarry; end
      UNIT_LOGIC: begin core = logicRes; coreCarry = ctrl.parityC & (^logicRes); end
      UNIT_SHIFT: begin core = shiftRes; coreCarry = shiftCarry; end
      default:    begin core = opB; coreCarry = carryFlag; end
    endcase
  end

  assign result    = core;
  assign carryNext = ctrl.flagUpd ? coreCarry : carryFlag;
  assign zeroNext  = ctrl.flagUpd ? (core == '0) : zeroFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
      zeroFlag  <= 1'b0;
    end else if (exec) begin
      carryFlag <= carryNext;
      zeroFlag  <= zeroNext;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              exec,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] immB,
  input  logic              useImm,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              carryNext,
  output logic              zeroNext,
  output logic              carryFlag,
  output logic              zeroFlag
);
  alu_ctrl_t ctrl;

  alu8_ctrl uCtrl (
    .exec    (exec),
    .opSel   (opSel),
    .ctrl    (ctrl),
    .writeEn (writeEn)
  );

  alu8_datapath #(.W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .exec      (exec),
    .ctrl      (ctrl),
    .opA       (opA),
    .regB      (regB),
    .immB      (immB),
    .useImm    (useImm),
    .result    (result),
    .carryNext (carryNext),
    .zeroNext  (zeroNext),
    .carryFlag (carryFlag),
    .zeroFlag  (zeroFlag)
  );
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker
  import alu8_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              exec,
  input logic [OP_W-1:0]   opSel,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic              carryNext,
  input logic              zeroNext,
  input logic              carryFlag,
  input logic              zeroFlag
);
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !exec |=> ($stable(carryFlag) && $stable(zeroFlag)));

  a_r10_take_next: assert property (@(posedge clk) disable iff (!rstN)
    exec |=> (carryFlag == $past(carryNext) && zeroFlag == $past(zeroNext)));

  a_r10_no_write_idle: assert property (@(posedge clk) disable iff (!rstN)
    !exec |-> !writeEn);

  a_r3_logic_carry_clear: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_AND || opSel == OP_OR || opSel == OP_XOR) |-> !carryNext);

  a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_TEST) |-> !writeEn);

  a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_CMP) |-> !writeEn);

  a_r6_load_keeps_flags: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_LOAD) |-> (carryNext == carryFlag && zeroNext == zeroFlag));

  a_r9_zero_matches: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn && opSel != OP_LOAD) |-> (zeroNext == (result == '0)));

  a_r12_unused_inert: assert property (@(posedge clk) disable iff (!rstN)
    (opSel > OP_RR) |-> (!writeEn && carryNext == carryFlag && zeroNext == zeroFlag));
endmodule

bind alu8_core alu8_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .exec      (exec),
  .opSel     (opSel),
  .result    (result),
  .writeEn   (writeEn),
  .carryNext (carryNext),
  .zeroNext  (zeroNext),
  .carryFlag (carryFlag),
  .zeroFlag  (zeroFlag)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       exec = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] opA = '0, regB = '0, immB = '0;
  logic       useImm = 1'b0;
  logic [7:0] result;
  logic       writeEn, carryNext, zeroNext, carryFlag, zeroFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic mC = 1'b0, mZ = 1'b0;   // bench copy of the flags

  always #5 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rstN(rstN), .exec(exec), .opSel(opSel), .opA(opA),
    .regB(regB), .immB(immB), .useImm(useImm), .result(result),
    .writeEn(writeEn), .carryNext(carryNext), .zeroNext(zeroNext),
    .carryFlag(carryFlag), .zeroFlag(zeroFlag)
  );

  // Returns {writes, carry, zero, result} from the requirement text.
  function automatic logic [10:0] refModel(input logic [4:0] op, input logic [7:0] a,
                                           input logic [7:0] b, input logic ci, input logic zi);
    logic [8:0] w;
    logic [7:0] r;
    logic wb, c, z, s;
    r = '0; wb = 1'b1; c = ci; z = zi;
    s = 1'b0;
    case (op)
      5'd0: r = b;
      5'd1: begin w = a + b; r = w[7:0]; c = w[8]; s = 1; end
      5'd2: begin w = a + b + ci; r = w[7:0]; c = w[8]; s = 1; end
      5'd3, 5'd9: begin w = {1'b0, a} - {1'b0, b}; r = w[7:0]; c = w[8]; s = 1;
                        if (op == 5'd9) wb = 0; end
      5'd4: begin w = {1'b0, a} - {1'b0, b} - ci; r = w[7:0]; c = w[8]; s = 1; end
      5'd5: begin r = a & b; c = 0; s = 1; end
      5'd6: begin r = a | b; c = 0; s = 1; end
      5'd7: begin r = a ^ b; c = 0; s = 1; end
      5'd8: begin r = a & b; c = ^r; wb = 0; s = 1; end
      5'd10: begin r = {a[6:0], 1'b0};  c = a[7]; s = 1; end
      5'd11: begin r = {a[6:0], 1'b1};  c = a[7]; s = 1; end
      5'd12: begin r = {a[6:0], a[0]};  c = a[7]; s = 1; end
      5'd13: begin r = {a[6:0], ci};    c = a[7]; s = 1; end
      5'd14: begin r = {a[6:0], a[7]};  c = a[7]; s = 1; end
      5'd15: begin r = {1'b0, a[7:1]};  c = a[0]; s = 1; end
      5'd16: begin r = {1'b1, a[7:1]};  c = a[0]; s = 1; end
      5'd17: begin r = {a[7], a[7:1]};  c = a[0]; s = 1; end
      5'd18: begin r = {ci, a[7:1]};    c = a[0]; s = 1; end
      5'd19: begin r = {a[0], a[7:1]};  c = a[0]; s = 1; end
      default: wb = 0;
    endcase
    if (s) z = (r == 8'h00);
    return {wb, c, z, r};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd0: return "R6";
      5'd1, 5'd2: return "R1";
      5'd3, 5'd4: return "R2";
      5'd5, 5'd6, 5'd7: return "R3";
      5'd8: return "R4";
      5'd9: return "R5";
      5'd10, 5'd11, 5'd12, 5'd13, 5'd14: return "R7";
      5'd15, 5'd16, 5'd17, 5'd18, 5'd19: return "R8";
      default: return "R12";
    endcase
  endfunction

  // Drive after a falling edge, judge combinational outputs, then flags after the edge.
  task automatic runOp(input logic [4:0] op, input logic [7:0] a, input logic [7:0] rb,
                       input logic [7:0] ib, input logic imm, input logic ex);
    logic [10:0] e;
    logic [7:0] b;
    string rq;
    @(negedge clk);
    opSel = op; opA = a; regB = rb; immB = ib; useImm = imm; exec = ex;
    b = imm ? ib : rb;       // R11 operand select
    e = refModel(op, a, b, mC, mZ);
    rq = reqOf(op);
    #1;
    check(rq, "writeEn", writeEn, ex & e[10]);
    if (e[10]) check(imm ? "R11" : rq, "result", result, e[7:0]);
    check(rq, "carryNext", carryNext, e[9]);
    check("R9", "zeroNext", zeroNext, e[8]);
    @(posedge clk);
    #1;
    if (ex) begin mC = e[9]; mZ = e[8]; end
    check("R10", "carryFlag", carryFlag, mC);
    check("R10", "zeroFlag", zeroFlag, mZ);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #1;
    check("R10", "reset carry", carryFlag, 0);
    check("R10", "reset zero", zeroFlag, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: wrap to zero, then a carry chain 0x01FF + 0x0001 = 0x0200
    runOp(5'd1, 8'hFF, 8'h01, 8'h00, 0, 1);
    runOp(5'd1, 8'hFF, 8'h01, 8'h00, 0, 1);
    runOp(5'd2, 8'h01, 8'h00, 8'h00, 0, 1);
    // R2: borrow chain and borrow on equal operands
    runOp(5'd3, 8'h00, 8'h01, 8'h00, 0, 1);
    runOp(5'd4, 8'h05, 8'h05, 8'h00, 0, 1);
    runOp(5'd4, 8'h05, 8'h04, 8'h00, 0, 1);
    // R3 after a carry set
    runOp(5'd10, 8'h80, 8'h00, 8'h00, 0, 1);
    runOp(5'd7, 8'h5A, 8'h00, 8'h5A, 1, 1);
    // R4 parity odd and even
    runOp(5'd8, 8'h07, 8'hFF, 8'h00, 0, 1);
    runOp(5'd8, 8'h03, 8'hFF, 8'h00, 0, 1);
    // R5 equal and less
    runOp(5'd9, 8'h42, 8'h00, 8'h42, 1, 1);
    runOp(5'd9, 8'h10, 8'h11, 8'h00, 0, 1);
    // R6 load keeps set carry
    runOp(5'd0, 8'h00, 8'h00, 8'h00, 0, 1);
    // R7 / R8 chained through carry
    runOp(5'd13, 8'h81, 8'h00, 8'h00, 0, 1);
    runOp(5'd13, 8'h40, 8'h00, 8'h00, 0, 1);
    runOp(5'd18, 8'h01, 8'h00, 8'h00, 0, 1);
    runOp(5'd17, 8'h80, 8'h00, 8'h00, 0, 1);
    runOp(5'd19, 8'h01, 8'h00, 8'h00, 0, 1);
    // R10 exec low: no update
    runOp(5'd1, 8'hFF, 8'hFF, 8'h00, 0, 0);
    // R12 unused code
    runOp(5'd25, 8'h00, 8'h00, 8'h00, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 23));
      runOp(op, 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
            ($urandom_range(0, 9) != 0));
    end
    finishRun();
  end
endmodule